// File: doc/BRIEF.md
# Inverted Timer Output Pin Override

This block decides what one general-purpose port pin drives. Normally the pin is governed by its own direction bit and data bit. Each of two timer channels (the lower one called channel 2 and the upper one called channel 3) has an enable bit. When a channel is enabled, the inverted output of that timer is placed on the pin and the pin is forced to drive. If both channels are enabled, channel 3 takes the pin. When the timers are cascaded into one 16-bit counter, channel 2 can never reach the pin.

The two enable bits sit in a small register that is written and read back through a register-bus port. A build parameter selects when enable changes reach the pin. In the default setting they apply on the next clock edge. In the edge-aligned setting, a channel's new enable value takes effect only at the clock edge that registers a level change of that channel's timer input. This keeps a partial timer pulse off the pin when the override is switched.

Top module: `tpm_pin_override`

## Requirements
- R1: After reset both enable bits read back as 0, pin_out equals port_data and pin_oe equals port_dir.
- R2: When reg_wr is high at a clock edge, reg_wdata is stored (bit 0 enables channel 2, bit 1 enables channel 3) and reg_rdata shows it from that edge on. Without reg_wr the stored bits keep their value.
- R3: With only channel 2 enabled and cascade16 low, pin_out equals the inverse of tmr_in[0].
- R4: With channel 3 enabled, pin_out equals the inverse of tmr_in[1], whatever channel 2's bit is.
- R5: While an override drives the pin, port_dir and port_data have no effect on pin_out or pin_oe.
- R6: With cascade16 high, channel 2 never drives the pin. With only channel 2 enabled the pin returns to port operation, and with channel 3 enabled channel 3 drives it.
- R7: While any override drives the pin, pin_oe is 1.
- R8: With no override driving the pin, pin_out equals port_data and pin_oe equals port_dir.
- R9: With EDGE_ALIGN=1, a channel's applied enable changes only at a clock edge where that channel's timer input differs from its level at the previous edge. An edge on the other channel's timer does not apply it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | NCH | Enable bits to store; bit 0 is channel 2, bit 1 is channel 3 |
| reg_rdata | output | NCH | Stored enable bits |
| tmr_in | input | NCH | Timer outputs; bit 0 is channel 2, bit 1 is channel 3 |
| cascade16 | input | 1 | Timers run as one cascaded 16-bit counter |
| port_dir | input | 1 | Normal port direction bit (1 = drive) |
| port_data | input | 1 | Normal port data bit |
| pin_out | output | 1 | Value driven onto the pin |
| pin_oe | output | 1 | Pin output enable |

## Verification
The bench covers both enables set with the two timer levels opposite each other. A design with the priority reversed would show channel 2's level there. It covers cascade mode with only channel 2 enabled, where a design that suppressed the channel without falling back would keep driving. It toggles the direction and data bits during an override, which a design that let them leak would reflect on the pin. In edge-aligned mode it changes enables with the timers held still and moves only the other channel's timer. A design that applied the change at once, or on any timer edge, would switch the pin too early.

// File: rtl/tpm_pkg.sv
package tpm_pkg;
    // Channel suppressed when the timers are cascaded (lowest channel)
    localparam int CASC_CH = 0;

    typedef enum logic {
        SRC_PORT  = 1'b0,
        SRC_TIMER = 1'b1
    } pin_src_e;
endpackage

// File: rtl/tpm_ctl_reg.sv
module tpm_ctl_reg #(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [NCH-1:0] wr_data,
    output logic [NCH-1:0] en_q
);
    typedef struct packed {
        logic [NCH-1:0] en;
    } ctl_t;

    ctl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.en = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_q = st_q.en;
endmodule

// File: rtl/tpm_edge_gate.sv
module tpm_edge_gate #(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] req_en,
    input  logic [NCH-1:0] tmr_in,
    output logic [NCH-1:0] act_en
);
    typedef struct packed {
        logic [NCH-1:0] act;
        logic [NCH-1:0] tprev;
    } gate_t;

    gate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < NCH; k++) begin
            // a level change on this channel's timer lets the request through
            if (tmr_in[k] != st_q.tprev[k]) begin
                st_d.act[k] = req_en[k];
            end
        end
        st_d.tprev = tmr_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_en = st_q.act;
endmodule

// File: rtl/tpm_src_sel.sv
module tpm_src_sel
    import tpm_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic [NCH-1:0] act_en,
    input  logic           cascade16,
    input  logic [NCH-1:0] tmr_in,
    input  logic           port_dir,
    input  logic           port_data,
    output logic           pin_out,
    output logic           pin_oe
);
    logic [NCH-1:0] eligible;
    pin_src_e       src;
    logic           tmr_lvl;

    always_comb begin
        eligible = act_en;
        if (cascade16) begin
            eligible[CASC_CH] = 1'b0;
        end
        src     = SRC_PORT;
        tmr_lvl = 1'b0;
        // ascending walk: the highest eligible channel is the last to win
        for (int k = 0; k < NCH; k++) begin
            if (eligible[k]) begin
                src     = SRC_TIMER;
                tmr_lvl = ~tmr_in[k];
            end
        end
    end

    always_comb begin
        if (src == SRC_TIMER) begin
            pin_out = tmr_lvl;
            pin_oe  = 1'b1;
        end else begin
            pin_out = port_data;
            pin_oe  = port_dir;
        end
    end
endmodule

// File: rtl/tpm_pin_override.sv
module tpm_pin_override #(
    parameter int NCH        = 2,
    parameter bit EDGE_ALIGN = 1'b0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_wr,
    input  logic [NCH-1:0] reg_wdata,
    output logic [NCH-1:0] reg_rdata,
    input  logic [NCH-1:0] tmr_in,
    input  logic           cascade16,
    input  logic           port_dir,
    input  logic           port_data,
    output logic           pin_out,
    output logic           pin_oe
);
    logic [NCH-1:0] req_en;
    logic [NCH-1:0] act_en;

    tpm_ctl_reg #(.NCH(NCH)) u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .wr_data (reg_wdata),
        .en_q    (req_en)
    );

    assign reg_rdata = req_en;

    generate
        if (EDGE_ALIGN) begin : g_gated
            tpm_edge_gate #(.NCH(NCH)) u_gate (
                .clk    (clk),
                .rst_n  (rst_n),
                .req_en (req_en),
                .tmr_in (tmr_in),
                .act_en (act_en)
            );
        end else begin : g_direct
            assign act_en = req_en;
        end
    endgenerate

    tpm_src_sel #(.NCH(NCH)) u_sel (
        .act_en    (act_en),
        .cascade16 (cascade16),
        .tmr_in    (tmr_in),
        .port_dir  (port_dir),
        .port_data (port_data),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );
endmodule

// File: rtl/tpm_pin_override_chk.sv
module tpm_pin_override_chk #(
    parameter int NCH        = 2,
    parameter bit EDGE_ALIGN = 1'b0
) (
    input logic           clk,
    input logic           rst_n,
    input logic           reg_wr,
    input logic [NCH-1:0] reg_wdata,
    input logic [NCH-1:0] reg_rdata,
    input logic [NCH-1:0] tmr_in,
    input logic           cascade16,
    input logic           port_dir,
    input logic           port_data,
    input logic [NCH-1:0] act_en,
    input logic           pin_out,
    input logic           pin_oe
);
    logic drives;
    logic [NCH-1:0] last_t;

    assign drives = act_en[NCH-1] || (act_en[0] && !cascade16);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_t <= '0;
        end else begin
            last_t <= tmr_in;
        end
    end

    assert_wr_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (reg_rdata == $past(reg_wdata)));

    assert_wr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> $stable(reg_rdata));

    assert_low_chan_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (act_en == NCH'(1) && !cascade16) |-> (pin_out == !tmr_in[0]));

    assert_top_chan_R4: assert property (@(posedge clk) disable iff (!rst_n)
        act_en[NCH-1] |-> (pin_out == !tmr_in[NCH-1]));

    assert_casc_fallback_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cascade16 && act_en == NCH'(1)) |-> (pin_out == port_data && pin_oe == port_dir));

    assert_oe_forced_R7: assert property (@(posedge clk) disable iff (!rst_n)
        drives |-> pin_oe);

    assert_port_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (act_en == '0) |-> (pin_out == port_data && pin_oe == port_dir));

    generate
        if (EDGE_ALIGN) begin : g_edge_chk
            for (genvar k = 0; k < NCH; k++) begin : g_ch
                assert_edge_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
                    (tmr_in[k] == last_t[k]) |=> $stable(act_en[k]));
            end
        end
    endgenerate
endmodule

bind tpm_pin_override tpm_pin_override_chk #(.NCH(NCH), .EDGE_ALIGN(EDGE_ALIGN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .tmr_in    (tmr_in),
    .cascade16 (cascade16),
    .port_dir  (port_dir),
    .port_data (port_data),
    .act_en    (act_en),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/tpm_pin_override_bench.sv
module tpm_pin_override_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_wdata = 2'b00;
    logic [1:0] tmr_in = 2'b00;
    logic       cascade16 = 1'b0;
    logic       port_dir = 1'b0;
    logic       port_data = 1'b0;
    logic [1:0] rd_i, rd_g;
    logic       out_i, oe_i, out_g, oe_g;
    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    tpm_pin_override #(.NCH(2), .EDGE_ALIGN(1'b0)) u_tpm_pin_override (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(rd_i), .tmr_in(tmr_in), .cascade16(cascade16),
        .port_dir(port_dir), .port_data(port_data), .pin_out(out_i), .pin_oe(oe_i));

    tpm_pin_override #(.NCH(2), .EDGE_ALIGN(1'b1)) u_gated (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(rd_g), .tmr_in(tmr_in), .cascade16(cascade16),
        .port_dir(port_dir), .port_data(port_data), .pin_out(out_g), .pin_oe(oe_g));

    // [12:9] requirement, [8:7] enables {ch3,ch2}, [6] cascade16, [5] port_dir,
    // [4] port_data, [3:2] timers {ch3,ch2}, [1] expected pin_out, [0] expected pin_oe
    localparam logic [12:0] VEC [12] = '{
        13'b1000_00_0_1_1_00_1_1,
        13'b1000_00_0_0_0_11_0_0,
        13'b0011_01_0_0_0_00_1_1,
        13'b0011_01_0_0_0_01_0_1,
        13'b0101_01_0_1_1_11_0_1,
        13'b0100_10_0_0_1_01_1_1,
        13'b0100_11_0_0_0_10_0_1,
        13'b0100_11_0_1_1_01_1_1,
        13'b0110_01_1_0_1_00_1_0,
        13'b0110_01_1_1_0_11_0_1,
        13'b0110_11_1_0_0_01_1_1,
        13'b0111_10_1_1_0_10_0_1
    };

    function automatic string tag(input int n);
        case (n)
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            7: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(input string t, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", t, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] v);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        port_dir  = 1'b1;
        port_data = 1'b0;
        tmr_in    = 2'b01;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1: reset state on both variants
        chk("R1 rdata", {2'b00, rd_i}, 4'b0000);
        chk("R1 pin", {2'b00, out_i, oe_i}, 4'b0001);
        chk("R1 gated rdata", {2'b00, rd_g}, 4'b0000);
        chk("R1 gated pin", {2'b00, out_g, oe_g}, 4'b0001);

        for (int i = 0; i < 12; i++) begin
            wr(VEC[i][8:7]);
            cascade16 = VEC[i][6];
            port_dir  = VEC[i][5];
            port_data = VEC[i][4];
            tmr_in    = VEC[i][3:2];
            #1;
            chk("R2 readback", {2'b00, rd_i}, {2'b00, VEC[i][8:7]});
            chk(tag(int'(VEC[i][12:9])), {2'b00, out_i, oe_i}, {2'b00, VEC[i][1:0]});
        end

        // R2: no write, stored bits hold
        reg_wdata = 2'b01;
        repeat (2) @(negedge clk);
        #1;
        chk("R2 hold", {2'b00, rd_i}, 4'b0010);

        // R7: override with port_dir low still drives
        wr(2'b01);
        cascade16 = 1'b0;
        port_dir  = 1'b0;
        tmr_in    = 2'b00;
        #1;
        chk("R7 oe forced", {2'b00, out_i, oe_i}, 4'b0011);

        // R9: flush the gated variant to disabled
        wr(2'b00);
        @(negedge clk); tmr_in = 2'b11;
        @(negedge clk); tmr_in = 2'b00;
        @(negedge clk);
        port_dir  = 1'b0;
        port_data = 1'b1;
        wr(2'b01);
        #1;
        chk("R9 held, timers still", {2'b00, out_g, oe_g}, 4'b0010);
        chk("R3 direct applies at once", {2'b00, out_i, oe_i}, 4'b0011);
        @(negedge clk);
        tmr_in = 2'b01;
        #1;
        chk("R9 before edge", {2'b00, out_g, oe_g}, 4'b0010);
        @(negedge clk);
        #1;
        chk("R9 after edge", {2'b00, out_g, oe_g}, 4'b0001);
        wr(2'b00);
        #1;
        chk("R9 disable deferred", {2'b00, out_g, oe_g}, 4'b0001);
        chk("R8 direct disable", {2'b00, out_i, oe_i}, 4'b0010);
        tmr_in = 2'b11;
        @(negedge clk);
        #1;
        chk("R9 other channel edge", {2'b00, out_g, oe_g}, 4'b0001);
        tmr_in = 2'b10;
        @(negedge clk);
        #1;
        chk("R9 own edge releases", {2'b00, out_g, oe_g}, 4'b0010);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule